// File: doc/BRIEF.md
# Floating-Point Exception Gating Unit

This block sits in front of the control-instruction path of a stack-based floating-point unit. For every control instruction it decides whether the instruction may run at all, must be replaced by a fault, or must be turned into an external legacy interrupt request. It also keeps the three 16-bit state words the instructions work on: control, status and tag. Arithmetic, the register stack contents and memory traffic belong to other blocks.

Each instruction arrives as a single-cycle strobe with a 3-bit kind, an operand word and a flag from the decoder saying whether this instruction checks pending exceptions. The unit samples the processor control bits for emulation, task-switched and native error reporting in the same cycle. One clock later it drives a fault pulse, an interrupt pulse, a store result, or the updated state words. Whenever new exception flags or masks arrive, the error-summary and backward flags are recomputed from the exceptions that are pending and not masked.

Top module: `fpx_exc_gate`

## Requirements
- R1: After reset the control word is 0x037F, the status word is 0x0000, the tag word is 0xFFFF, and every pulse output is low.
- R2: If the emulation bit or the task-switched bit is set when an instruction is strobed, `fault_nm` pulses and no state word changes. No store result is produced.
- R3: If the instruction checks pending exceptions, status bit 7 (summary) is set, the native-error bit is 1, and no R2 condition applies, then `fault_mf` pulses and no state word changes.
- R4: Under the conditions of R3 but with the native-error bit at 0, `irq_legacy` pulses instead of `fault_mf`, and no state word changes.
- R5: If the instruction does not check pending exceptions, a set summary bit is ignored and the instruction executes.
- R6: Kind 1 loads the control word from the operand. Exception flags sit at status bits 5:0 and their masks at control bits 5:0. Status bits 7 and 15 are then both set if any flag is set whose mask is clear, and both cleared otherwise.
- R7: Kind 2 loads the status word from the operand, including the top-of-stack field at bits 13:11, and recomputes bits 7 and 15 against the current masks as in R6.
- R8: Kind 3 clears status bits 15, 7, 6 and 5:0 and leaves bits 14 and 13:8 unchanged.
- R9: Kind 4 sets control to 0x037F, status to 0x0000 and tag to 0xFFFF.
- R10: Kind 5 presents the control word and kind 6 presents the status word on `store_data`, with `store_valid` high for one cycle.
- R11: Kind 0 changes no state and produces no output pulse. Kind 7 loads the tag word from the operand.
- R12: The emulation and task-switched check takes priority over the pending-exception check, so at most one of `fault_nm`, `fault_mf`, `irq_legacy` and `store_valid` is high in any cycle.
- R13: Every output pulse follows the strobe by exactly one clock and lasts one cycle for a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction strobe |
| op_kind | input | 3 | Instruction kind (0 no-op, 1 load control, 2 load status, 3 clear exceptions, 4 initialise, 5 store control, 6 store status, 7 load tag) |
| op_chk_pend | input | 1 | Instruction checks pending exceptions |
| op_data | input | 16 | Operand word for the load kinds |
| cr0_em | input | 1 | Emulation bit |
| cr0_ts | input | 1 | Task-switched bit |
| cr0_ne | input | 1 | Native error reporting select |
| fault_nm | output | 1 | Device-not-available fault pulse |
| fault_mf | output | 1 | Internal math fault pulse |
| irq_legacy | output | 1 | External legacy interrupt request pulse |
| store_valid | output | 1 | Store result valid pulse |
| store_data | output | 16 | Stored word |
| ctrl_word | output | 16 | Current control word |
| stat_word | output | 16 | Current status word |
| tag_word | output | 16 | Current tag word |

## Verification
Status loads are tried with all exceptions masked, with some unmasked and with none pending. These separate the set path of the summary/backward recompute from the clear path, and show whether the top-of-stack and reserved bits survive. A pending summary is then presented with the native-error bit at each value, with the pending check flag off, and together with the emulation and task-switched bits. These cases tell apart the four outcomes of the gate and their priority. Idle cycles after each fault show that pulses last a single cycle and that a faulting instruction left every word untouched.

// File: rtl/fpx_pkg.sv
// Package: shared kinds and bit positions for the exception gating unit.
// Assumes 16-bit state words with the flag layout given in the brief.
package fpx_pkg;
    localparam int WORD_W  = 16;
    localparam int EXC_N   = 6;
    localparam int SUM_BIT = 7;
    localparam int SF_BIT  = 6;
    localparam int BK_BIT  = 15;
    localparam logic [WORD_W-1:0] CW_INIT = 16'h037F;
    localparam logic [WORD_W-1:0] SW_INIT = 16'h0000;
    localparam logic [WORD_W-1:0] TW_INIT = 16'hFFFF;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDCW = 3'd1,
        OP_LDSW = 3'd2,
        OP_CLEX = 3'd3,
        OP_INIT = 3'd4,
        OP_STCW = 3'd5,
        OP_STSW = 3'd6,
        OP_LDTW = 3'd7
    } op_e;
endpackage

// File: rtl/fpx_unmask_eval.sv
// fpx_unmask_eval: reports whether any exception flag is set while its
// mask is clear. Purely combinational; flag i pairs with mask i.
module fpx_unmask_eval #(
    parameter int N = 6
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] masks,
    output logic         pending
);
    logic [N-1:0] hit;

    // One AND per flag/mask pair.
    for (genvar g = 0; g < N; g++) begin : g_pair
        assign hit[g] = flags[g] & ~masks[g];
    end

    // Reduce the per-bit hits to one pending indication.
    assign pending = |hit;
endmodule

// File: rtl/fpx_gate_decide.sv
// fpx_gate_decide: classifies a strobed instruction into one of four
// outcomes. Unit-unavailable wins over the pending check; the pending
// check only matters when the decoder asks for it. Combinational.
module fpx_gate_decide (
    input  logic op_valid,
    input  logic em,
    input  logic ts,
    input  logic ne,
    input  logic chk_pend,
    input  logic summary,
    output logic go_nm,
    output logic go_mf,
    output logic go_irq,
    output logic go_exec
);
    logic unavail;
    logic pend_hit;

    // Priority chain: unavailable, then pending error, then execute.
    always_comb begin
        unavail  = em | ts;
        pend_hit = chk_pend & summary;
        go_nm    = op_valid & unavail;
        go_mf    = op_valid & ~unavail & pend_hit & ne;
        go_irq   = op_valid & ~unavail & pend_hit & ~ne;
        go_exec  = op_valid & ~unavail & ~pend_hit;
    end
endmodule

// File: rtl/fpx_word_regs.sv
// fpx_word_regs: holds control, status and tag words and applies the
// effect of one executed instruction per cycle. Assumes the caller only
// raises exec for instructions the gate allowed.
module fpx_word_regs
    import fpx_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = EXC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec,
    input  op_e          kind,
    input  logic [W-1:0] data,
    output logic [W-1:0] cw,
    output logic [W-1:0] sw,
    output logic [W-1:0] tw
);
    logic         pend_new_mask;
    logic         pend_new_flag;
    logic [W-1:0] clex_keep;

    // New masks against the held flags (control-word load).
    fpx_unmask_eval #(.N(N)) u_eval_cw (
        .flags   (sw[N-1:0]),
        .masks   (data[N-1:0]),
        .pending (pend_new_mask)
    );

    // New flags against the held masks (status-word load).
    fpx_unmask_eval #(.N(N)) u_eval_sw (
        .flags   (data[N-1:0]),
        .masks   (cw[N-1:0]),
        .pending (pend_new_flag)
    );

    // Mask of status bits that survive clear-exceptions.
    always_comb begin
        clex_keep            = '1;
        clex_keep[N-1:0]     = '0;
        clex_keep[SF_BIT]    = 1'b0;
        clex_keep[SUM_BIT]   = 1'b0;
        clex_keep[BK_BIT]    = 1'b0;
    end

    // State update for the allowed instruction kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw <= CW_INIT;
            sw <= SW_INIT;
            tw <= TW_INIT;
        end else if (exec) begin
            case (kind)
                OP_LDCW: begin
                    cw          <= data;
                    sw[SUM_BIT] <= pend_new_mask;
                    sw[BK_BIT]  <= pend_new_mask;
                end
                OP_LDSW: begin
                    sw          <= data;
                    sw[SUM_BIT] <= pend_new_flag;
                    sw[BK_BIT]  <= pend_new_flag;
                end
                OP_CLEX: sw <= sw & clex_keep;
                OP_INIT: begin
                    cw <= CW_INIT;
                    sw <= SW_INIT;
                    tw <= TW_INIT;
                end
                OP_LDTW: tw <= data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fpx_exc_gate.sv
// fpx_exc_gate: top of the floating-point exception gating unit. Gates
// each control instruction on the unit-available bits and the pending
// summary, issues one-cycle fault/interrupt/store pulses one clock after
// the strobe, and keeps the state words. Synchronous active-low reset.
module fpx_exc_gate
    import fpx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_kind,
    input  logic         op_chk_pend,
    input  logic [W-1:0] op_data,
    input  logic         cr0_em,
    input  logic         cr0_ts,
    input  logic         cr0_ne,
    output logic         fault_nm,
    output logic         fault_mf,
    output logic         irq_legacy,
    output logic         store_valid,
    output logic [W-1:0] store_data,
    output logic [W-1:0] ctrl_word,
    output logic [W-1:0] stat_word,
    output logic [W-1:0] tag_word
);
    op_e  kind;
    logic go_nm, go_mf, go_irq, go_exec;
    logic is_store;

    assign kind = op_e'(op_kind);

    fpx_gate_decide u_decide (
        .op_valid (op_valid),
        .em       (cr0_em),
        .ts       (cr0_ts),
        .ne       (cr0_ne),
        .chk_pend (op_chk_pend),
        .summary  (stat_word[SUM_BIT]),
        .go_nm    (go_nm),
        .go_mf    (go_mf),
        .go_irq   (go_irq),
        .go_exec  (go_exec)
    );

    fpx_word_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .exec  (go_exec),
        .kind  (kind),
        .data  (op_data),
        .cw    (ctrl_word),
        .sw    (stat_word),
        .tw    (tag_word)
    );

    // Store kinds only produce a result when executed.
    assign is_store = (kind == OP_STCW) || (kind == OP_STSW);

    // Registered one-cycle outcome pulses and store result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_nm    <= 1'b0;
            fault_mf    <= 1'b0;
            irq_legacy  <= 1'b0;
            store_valid <= 1'b0;
            store_data  <= '0;
        end else begin
            fault_nm    <= go_nm;
            fault_mf    <= go_mf;
            irq_legacy  <= go_irq;
            store_valid <= go_exec & is_store;
            if (go_exec && is_store)
                store_data <= (kind == OP_STCW) ? ctrl_word : stat_word;
        end
    end
endmodule

// File: rtl/fpx_exc_gate_chk.sv
// fpx_exc_gate_chk: temporal properties of the gating unit, bound to the
// top. Observes ports only.
module fpx_exc_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic        cr0_em,
    input logic        cr0_ts,
    input logic        cr0_ne,
    input logic        fault_nm,
    input logic        fault_mf,
    input logic        irq_legacy,
    input logic        store_valid,
    input logic [15:0] ctrl_word,
    input logic [15:0] stat_word,
    input logic [15:0] tag_word
);
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_nm, fault_mf, irq_legacy, store_valid}));

    p_nm_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_nm |-> ($stable(ctrl_word) && $stable(stat_word) && $stable(tag_word)));

    p_mf_ne_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_mf |-> ($past(cr0_ne) && $stable(ctrl_word) && $stable(stat_word)));

    p_irq_ne_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_legacy |-> (!$past(cr0_ne) && $stable(stat_word)));

    p_sum_bk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[7] == stat_word[15]);

    p_pulse_src_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_nm || fault_mf || irq_legacy || store_valid) |-> $past(op_valid));

    p_nm_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_nm |-> ($past(cr0_em) || $past(cr0_ts)));

    p_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd4 && !cr0_em && !cr0_ts && !stat_word[7])
        |=> (ctrl_word == 16'h037F && stat_word == 16'h0000 && tag_word == 16'hFFFF));
endmodule

bind fpx_exc_gate fpx_exc_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .cr0_em      (cr0_em),
    .cr0_ts      (cr0_ts),
    .cr0_ne      (cr0_ne),
    .fault_nm    (fault_nm),
    .fault_mf    (fault_mf),
    .irq_legacy  (irq_legacy),
    .store_valid (store_valid),
    .ctrl_word   (ctrl_word),
    .stat_word   (stat_word),
    .tag_word    (tag_word)
);

// File: tb/sim_fpx_exc_gate.sv
// Scoreboard bench: driver pushes expected outcomes, monitor pops them.
module sim_fpx_exc_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic        op_chk_pend = 1'b0;
    logic [15:0] op_data = 16'h0;
    logic        cr0_em = 1'b0, cr0_ts = 1'b0, cr0_ne = 1'b1;
    logic        fault_nm, fault_mf, irq_legacy, store_valid;
    logic [15:0] store_data, ctrl_word, stat_word, tag_word;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [67:0] v;   // {nm, mf, irq, sv, sd, cw, sw, tw}
        string       req;
    } exp_t;
    exp_t q[$];

    logic [15:0] m_cw = 16'h037F, m_sw = 16'h0000, m_tw = 16'hFFFF;

    always #2 clk = ~clk;   // 250 MHz

    fpx_exc_gate u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_chk_pend(op_chk_pend), .op_data(op_data), .cr0_em(cr0_em),
        .cr0_ts(cr0_ts), .cr0_ne(cr0_ne), .fault_nm(fault_nm),
        .fault_mf(fault_mf), .irq_legacy(irq_legacy),
        .store_valid(store_valid), .store_data(store_data),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .tag_word(tag_word)
    );

    function automatic logic pend(input logic [15:0] f, input logic [15:0] m);
        return |(f[5:0] & ~m[5:0]);
    endfunction

    logic [15:0] last_sd = 16'h0;

    // Drive one instruction and push the outcome the requirements predict.
    task automatic do_op(input logic [2:0] k, input logic chk, input logic [15:0] d,
                         input logic em, input logic ts, input logic ne, input string req);
        exp_t e;
        logic nm = 0, mf = 0, irq = 0, sv = 0;
        @(negedge clk);
        op_valid = 1; op_kind = k; op_chk_pend = chk; op_data = d;
        cr0_em = em; cr0_ts = ts; cr0_ne = ne;
        if (em || ts) nm = 1;
        else if (chk && m_sw[7]) begin mf = ne; irq = !ne; end
        else begin
            case (k)
                3'd1: begin m_cw = d; m_sw[7] = pend(m_sw, d); m_sw[15] = m_sw[7]; end
                3'd2: begin m_sw = d; m_sw[7] = pend(d, m_cw); m_sw[15] = m_sw[7]; end
                3'd3: m_sw = m_sw & 16'h7F00;
                3'd4: begin m_cw = 16'h037F; m_sw = 16'h0; m_tw = 16'hFFFF; end
                3'd5: begin sv = 1; last_sd = m_cw; end
                3'd6: begin sv = 1; last_sd = m_sw; end
                3'd7: m_tw = d;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        e.v = {nm, mf, irq, sv, last_sd, m_cw, m_sw, m_tw};
        e.req = req;
        q.push_back(e);
        op_valid = 0; cr0_em = 0; cr0_ts = 0;
    endtask

    // Idle cycle: expect no pulse and unchanged state.
    task automatic idle(input string req);
        exp_t e;
        @(posedge clk); #1;
        e.v = {4'b0, last_sd, m_cw, m_sw, m_tw};
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [67:0] act;
            e = q.pop_front();
            act = {fault_nm, fault_mf, irq_legacy, store_valid, store_data,
                   ctrl_word, stat_word, tag_word};
            tests++;
            if (act !== e.v) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", e.req, act, e.v);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        tests++;   // R1 reset state
        if ({fault_nm, fault_mf, irq_legacy, store_valid, ctrl_word, stat_word, tag_word}
            !== {4'b0, 16'h037F, 16'h0000, 16'hFFFF}) begin
            fails++;
            $display("FAIL R1 actual=%h %h %h expected=037f 0000 ffff",
                     ctrl_word, stat_word, tag_word);
        end
        do_op(3'd5, 0, 16'h0, 0, 0, 1, "R10 store control");
        do_op(3'd6, 0, 16'h0, 0, 0, 1, "R10 store status");
        do_op(3'd2, 1, 16'h7F45, 0, 0, 1, "R7 load status all masked");
        do_op(3'd1, 1, 16'h037A, 0, 0, 1, "R6 unmask sets summary");
        do_op(3'd0, 1, 16'h0, 0, 0, 1, "R3 pending math fault");
        idle("R13 pulse ends");
        do_op(3'd0, 1, 16'h0, 0, 0, 0, "R4 pending legacy irq");
        idle("R13 irq ends");
        do_op(3'd4, 1, 16'h0, 1, 0, 1, "R12 em beats pending");
        do_op(3'd4, 0, 16'h0, 0, 1, 1, "R2 ts blocks init");
        idle("R13 nm ends");
        do_op(3'd7, 1, 16'h1234, 0, 0, 0, "R4 load tag blocked");
        do_op(3'd6, 0, 16'h0, 0, 0, 1, "R5 store ignores summary");
        do_op(3'd7, 0, 16'h5A5A, 0, 0, 1, "R11 load tag");
        do_op(3'd3, 0, 16'h0, 0, 0, 1, "R8 clear exceptions");
        do_op(3'd1, 1, 16'h0340, 0, 0, 1, "R6 no pending clears");
        do_op(3'd0, 1, 16'hFFFF, 0, 0, 1, "R11 no-op");
        do_op(3'd2, 1, 16'h2801, 0, 0, 1, "R7 unmasked flag sets summary");
        do_op(3'd1, 0, 16'h037F, 0, 0, 1, "R6 remask clears summary");
        do_op(3'd4, 1, 16'h0, 0, 0, 1, "R9 initialise");
        do_op(3'd5, 1, 16'h0, 0, 0, 1, "R10 store after init");
        idle("R13 store ends");
        idle("R9 settle");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule